// File: doc/BRIEF.md
# Frame FIFO Read Sequencer

This block sits between a host and the read port of an external frame buffer FIFO. It owns three control pins toward the FIFO: an active-low pointer rewind, an active-low output drive enable and a read strobe clock. It also samples the FIFO's 8-bit data bus. The host issues one of four commands, each a single-cycle request: open (rewind the read pointer and enable the output), read one byte, read a word (two strobes, of which only the second byte is returned) and close (disable the output, give one dummy strobe and park the strobe high).

Each command runs as a fixed series of pin steps. Every step holds its pin levels for `SETTLE` system clocks, so each half-phase of the read strobe meets the FIFO's settling time. While a command runs, `busy` is high and any other request is dropped. Read results appear on `data_out` with a one-cycle `data_valid` pulse. A read issued while the FIFO is not open is still carried out, but it raises a sticky `seq_error`.

Top module: `fifo_rd_seq`

## Requirements
- R1: After reset, `fifo_rewind_n`, `fifo_drive_n` and `fifo_sclk` are 1; `busy`, `data_valid` and `seq_error` are 0; `data_out` is 0.
- R2: An open command (`cmd_op`=0) drives `fifo_rewind_n`, `fifo_drive_n` and `fifo_sclk` low together. `fifo_sclk` then goes high for one step and low for one step, all while the rewind stays low. `fifo_rewind_n` returns high when the command completes and `fifo_drive_n` stays low. `busy` lasts 3·SETTLE cycles and no `data_valid` is produced.
- R3: Every level of `fifo_sclk` that begins inside a command is held for at least SETTLE clocks.
- R4: A byte read (`cmd_op`=1) gives one strobe: high for SETTLE cycles, then low for SETTLE cycles. `fifo_data` is sampled in the last cycle of the high phase. `busy` lasts 2·SETTLE cycles.
- R5: A word read (`cmd_op`=2) gives two strobes (high, low, high, low, each SETTLE cycles), so `busy` lasts 4·SETTLE cycles. The byte returned is the one sampled during the second strobe.
- R6: A close command (`cmd_op`=3) drives `fifo_drive_n` high from its first cycle. `fifo_sclk` then runs low, high (dummy strobe, data discarded), low, high, each for SETTLE cycles, so `busy` lasts 4·SETTLE cycles. The command ends with the strobe high and produces no `data_valid`.
- R7: A request made while `busy` is high has no effect on the pins, the timing or the result of the command in progress.
- R8: A byte or word read accepted when no open has been accepted since reset or since the last close still runs in full, and it sets `seq_error`. `seq_error` stays set until the next open is accepted, which clears it.
- R9: `data_valid` pulses for exactly one cycle, in the first cycle after a byte or word read completes, with `busy` low. `data_out` changes only in a cycle where `data_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when `busy` is low |
| cmd_op | input | 2 | Opcode: 0 open, 1 byte read, 2 word read, 3 close |
| fifo_data | input | 8 | FIFO read data bus |
| busy | output | 1 | A command sequence is running |
| data_out | output | 8 | Last byte returned by a read |
| data_valid | output | 1 | One-cycle pulse marking a new `data_out` |
| seq_error | output | 1 | Sticky flag: a read was made while the FIFO was not open |
| fifo_rewind_n | output | 1 | Active-low read pointer rewind to the FIFO |
| fifo_drive_n | output | 1 | Active-low output drive enable to the FIFO |
| fifo_sclk | output | 1 | Read strobe clock to the FIFO |

## Verification
The checker watches four things on every cycle: the rewind is low only inside a command, the strobe never changes level before SETTLE clocks have passed, the result pulse never overlaps `busy`, and `data_out` holds still outside that pulse. The bench scenarios cover what depends on the order of steps and on the FIFO's contents. A FIFO model advances its read pointer on each strobe rising edge, which shows that the open rewinds the pointer and that a word read returns the second byte. The scenarios also cover the exact busy lengths per opcode, the dummy strobe and high park of the close, a dropped request during a read, and the setting and clearing of the error flag.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [1:0] {
        OP_OPEN  = 2'd0,
        OP_BYTE  = 2'd1,
        OP_WORD  = 2'd2,
        OP_CLOSE = 2'd3
    } fsr_op_e;

    // Strobe level held during a given step of a command
    function automatic logic step_level(fsr_op_e op, logic [1:0] idx);
        case (op)
            OP_OPEN:  return (idx == 2'd1);
            OP_BYTE:  return (idx == 2'd0);
            OP_WORD:  return (idx == 2'd0) || (idx == 2'd2);
            default:  return (idx == 2'd1) || (idx == 2'd3);
        endcase
    endfunction

    // Index of the final step of a command
    function automatic logic [1:0] final_step(fsr_op_e op);
        case (op)
            OP_OPEN: return 2'd2;
            OP_BYTE: return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    // Step at whose end the data bus is captured for the result
    function automatic logic keep_step(fsr_op_e op, logic [1:0] idx);
        return ((op == OP_BYTE) && (idx == 2'd0)) ||
               ((op == OP_WORD) && (idx == 2'd2));
    endfunction

endpackage

// File: rtl/fsr_timer.sv
module fsr_timer #(
    parameter int SETTLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(SETTLE - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = RELOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == '0);
endmodule

// File: rtl/fsr_capture.sv
module fsr_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grab,
    input  logic          publish,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dvalid
);
    typedef struct packed {
        logic [DW-1:0] hold;
        logic [DW-1:0] outv;
        logic          valid;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = publish;
        if (grab)    cap_d.hold = din;
        if (publish) cap_d.outv = cap_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign dout   = cap_q.outv;
    assign dvalid = cap_q.valid;
endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
    import fsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       expire,
    output logic       load,
    output logic       grab,
    output logic       publish,
    output logic       busy,
    output logic       seq_error,
    output logic       rewind_n,
    output logic       drive_n,
    output logic       sclk
);
    typedef struct packed {
        logic       busy;
        fsr_op_e    op;
        logic [1:0] step;
        logic       rewind_n;
        logic       drive_n;
        logic       sclk;
        logic       opened;
        logic       err;
    } ctl_t;

    localparam ctl_t CTL_RST = '{busy: 1'b0, op: OP_OPEN, step: 2'd0,
                                 rewind_n: 1'b1, drive_n: 1'b1, sclk: 1'b1,
                                 opened: 1'b0, err: 1'b0};

    ctl_t ctl_d, ctl_q;
    fsr_op_e req_op;

    assign req_op = fsr_op_e'(cmd_op);

    always_comb begin
        ctl_d   = ctl_q;
        load    = 1'b0;
        grab    = 1'b0;
        publish = 1'b0;
        if (!ctl_q.busy) begin
            if (cmd_valid) begin
                ctl_d.busy = 1'b1;
                ctl_d.op   = req_op;
                ctl_d.step = 2'd0;
                ctl_d.sclk = step_level(req_op, 2'd0);
                load       = 1'b1;
                case (req_op)
                    OP_OPEN: begin
                        ctl_d.rewind_n = 1'b0;
                        ctl_d.drive_n  = 1'b0;
                        ctl_d.opened   = 1'b1;
                        ctl_d.err      = 1'b0;
                    end
                    OP_CLOSE: begin
                        ctl_d.drive_n = 1'b1;
                        ctl_d.opened  = 1'b0;
                    end
                    default: begin
                        if (!ctl_q.opened) ctl_d.err = 1'b1;
                    end
                endcase
            end
        end else if (expire) begin
            grab = keep_step(ctl_q.op, ctl_q.step);
            if (ctl_q.step == final_step(ctl_q.op)) begin
                ctl_d.busy = 1'b0;
                if (ctl_q.op == OP_OPEN) ctl_d.rewind_n = 1'b1;
                publish = (ctl_q.op == OP_BYTE) || (ctl_q.op == OP_WORD);
            end else begin
                ctl_d.step = ctl_q.step + 2'd1;
                ctl_d.sclk = step_level(ctl_q.op, ctl_q.step + 2'd1);
                load       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign busy      = ctl_q.busy;
    assign seq_error = ctl_q.err;
    assign rewind_n  = ctl_q.rewind_n;
    assign drive_n   = ctl_q.drive_n;
    assign sclk      = ctl_q.sclk;
endmodule

// File: rtl/fifo_rd_seq.sv
module fifo_rd_seq #(
    parameter int SETTLE = 4,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [DW-1:0] fifo_data,
    output logic          busy,
    output logic [DW-1:0] data_out,
    output logic          data_valid,
    output logic          seq_error,
    output logic          fifo_rewind_n,
    output logic          fifo_drive_n,
    output logic          fifo_sclk
);
    logic load, expire, grab, publish;

    fsr_timer #(.SETTLE(SETTLE)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .expire (expire)
    );

    fsr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .expire    (expire),
        .load      (load),
        .grab      (grab),
        .publish   (publish),
        .busy      (busy),
        .seq_error (seq_error),
        .rewind_n  (fifo_rewind_n),
        .drive_n   (fifo_drive_n),
        .sclk      (fifo_sclk)
    );

    fsr_capture #(.DW(DW)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .grab    (grab),
        .publish (publish),
        .din     (fifo_data),
        .dout    (data_out),
        .dvalid  (data_valid)
    );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
    parameter int SETTLE = 4,
    parameter int DW     = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic [DW-1:0] data_out,
    input logic          data_valid,
    input logic          fifo_rewind_n,
    input logic          fifo_sclk
);
    logic        prev_q;
    int unsigned run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            run_q  <= SETTLE;
        end else begin
            prev_q <= fifo_sclk;
            if (fifo_sclk != prev_q)  run_q <= 1;
            else if (run_q < SETTLE)  run_q <= run_q + 1;
        end
    end

    AST_REWIND_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_rewind_n |-> busy); // R2
    AST_STROBE_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_sclk != prev_q) |-> (run_q >= SETTLE)); // R3
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> !busy); // R9
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid); // R9
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_out) |-> data_valid); // R9
endmodule

bind fifo_rd_seq fsr_checker #(.SETTLE(SETTLE), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .data_out      (data_out),
    .data_valid    (data_valid),
    .fifo_rewind_n (fifo_rewind_n),
    .fifo_sclk     (fifo_sclk)
);

// File: tb/sim_fifo_rd_seq.sv
`timescale 1ns/1ps
module sim_fifo_rd_seq;
    localparam int S = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] fifo_data;
    logic       busy, data_valid, seq_error;
    logic [7:0] data_out;
    logic       fifo_rewind_n, fifo_drive_n, fifo_sclk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fifo_rd_seq #(.SETTLE(S), .DW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .fifo_data(fifo_data), .busy(busy), .data_out(data_out),
        .data_valid(data_valid), .seq_error(seq_error),
        .fifo_rewind_n(fifo_rewind_n), .fifo_drive_n(fifo_drive_n),
        .fifo_sclk(fifo_sclk)
    );

    // FIFO read port model: pointer steps on each strobe rising edge
    int unsigned ptr = 0;
    int unsigned rises = 0;
    function automatic logic [7:0] pat(int unsigned p);
        return 8'(p * 29 + 53);
    endfunction
    always @(posedge fifo_sclk) begin
        rises <= rises + 1;
        if (!fifo_rewind_n) ptr <= 0;
        else                ptr <= ptr + 1;
    end
    assign fifo_data = fifo_drive_n ? 8'hFF : pat(ptr);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    // Results of one command
    int  r_busy, r_hi, r_min_run, r_valid_in_busy, r_rises;
    bit  r_rewind_low, r_drive_high_all, r_valid_end;
    logic [7:0] r_data;

    task automatic run_cmd(input logic [1:0] op, input bit inject);
        int run; logic last; int guard; int rise0;
        rise0 = rises;
        @(negedge clk); cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk); cmd_valid = 1'b0;
        r_busy = 0; r_hi = 0; r_min_run = 1000; r_valid_in_busy = 0;
        r_rewind_low = 1'b0; r_drive_high_all = 1'b1;
        run = 0; last = fifo_sclk; guard = 0;
        while (busy && guard < 1000) begin
            r_busy++;
            if (fifo_sclk) r_hi++;
            if (!fifo_rewind_n) r_rewind_low = 1'b1;
            if (!fifo_drive_n) r_drive_high_all = 1'b0;
            if (data_valid) r_valid_in_busy++;
            if (r_busy > 1 && fifo_sclk != last) begin
                if (run < r_min_run) r_min_run = run;
                run = 0;
            end
            run++; last = fifo_sclk;
            if (inject && r_busy == 1) begin cmd_valid = 1'b1; cmd_op = 2'd3; end
            if (inject && r_busy == 2) cmd_valid = 1'b0;
            @(negedge clk); guard++;
        end
        cmd_valid = 1'b0;
        r_valid_end = data_valid;
        r_data = data_out;
        r_rises = rises - rise0;
        @(negedge clk);
        check(!data_valid, "R9 valid one cycle", data_valid, 0);
    endtask

    task automatic t_reset;
        check(fifo_rewind_n && fifo_drive_n && fifo_sclk, "R1 pins high",
              {fifo_rewind_n, fifo_drive_n, fifo_sclk}, 7);
        check(!busy && !data_valid && !seq_error, "R1 flags low",
              {busy, data_valid, seq_error}, 0);
        check(data_out == 8'h00, "R1 data_out", data_out, 0);
    endtask

    task automatic t_read_unopened(input string tag);
        run_cmd(2'd1, 1'b0);
        check(r_busy == 2*S, {tag, " R8 read still runs"}, r_busy, 2*S);
        check(seq_error, {tag, " R8 error set"}, seq_error, 1);
        check(r_valid_end && r_data == 8'hFF, {tag, " R8 data with output off"}, r_data, 8'hFF);
    endtask

    task automatic t_open;
        run_cmd(2'd0, 1'b0);
        check(r_busy == 3*S, "R2 busy length", r_busy, 3*S);
        check(r_hi == S, "R2 one strobe high phase", r_hi, S);
        check(r_rewind_low, "R2 rewind low during open", r_rewind_low, 1);
        check(ptr == 0, "R2 pointer rewound", ptr, 0);
        check(fifo_rewind_n && !fifo_drive_n && !fifo_sclk, "R2 end pins",
              {fifo_rewind_n, fifo_drive_n, fifo_sclk}, 3'b100);
        check(!r_valid_end && r_valid_in_busy == 0, "R2 no valid", r_valid_end, 0);
        check(!seq_error, "R8 error cleared by open", seq_error, 0);
        check(r_min_run >= S, "R3 half phase length", r_min_run, S);
    endtask

    task automatic t_byte;
        int unsigned p0;
        p0 = ptr;
        run_cmd(2'd1, 1'b0);
        check(r_busy == 2*S && r_hi == S, "R4 byte timing", r_busy, 2*S);
        check(r_valid_end, "R9 valid after byte", r_valid_end, 1);
        check(r_data == pat(p0 + 1), "R4 byte data", r_data, pat(p0 + 1));
        check(!seq_error, "R8 no error when open", seq_error, 0);
        check(r_min_run == S, "R3 byte half phase", r_min_run, S);
    endtask

    task automatic t_word;
        int unsigned p0;
        p0 = ptr;
        run_cmd(2'd2, 1'b0);
        check(r_busy == 4*S && r_hi == 2*S, "R5 word timing", r_busy, 4*S);
        check(r_rises == 2, "R5 two strobes", r_rises, 2);
        check(r_valid_end && r_valid_in_busy == 0, "R9 single valid after word", r_valid_in_busy, 0);
        check(r_data == pat(p0 + 2), "R5 second byte returned", r_data, pat(p0 + 2));
        check(r_min_run == S, "R3 word half phase", r_min_run, S);
    endtask

    task automatic t_ignore;
        int unsigned p0;
        p0 = ptr;
        run_cmd(2'd1, 1'b1);
        check(r_busy == 2*S, "R7 busy unchanged", r_busy, 2*S);
        check(!fifo_drive_n, "R7 close request dropped", fifo_drive_n, 0);
        check(r_data == pat(p0 + 1), "R7 result intact", r_data, pat(p0 + 1));
        check(r_rises == 1, "R7 strobe count", r_rises, 1);
    endtask

    task automatic t_close;
        run_cmd(2'd3, 1'b0);
        check(r_busy == 4*S && r_hi == 2*S, "R6 close timing", r_busy, 4*S);
        check(r_drive_high_all && fifo_drive_n, "R6 output off", fifo_drive_n, 1);
        check(fifo_sclk, "R6 strobe parked high", fifo_sclk, 1);
        check(r_rises == 2, "R6 dummy strobe", r_rises, 2);
        check(!r_valid_end && r_valid_in_busy == 0, "R6 no valid", r_valid_end, 0);
        check(r_min_run == S, "R3 close half phase", r_min_run, S);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_unopened("after reset");
        t_open();
        t_byte();
        t_word();
        t_ignore();
        t_close();
        t_read_unopened("after close");
        run_cmd(2'd2, 1'b0);
        check(seq_error, "R8 error sticky", seq_error, 1);
        t_open();
        t_word();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule